// File: doc/BRIEF.md
# Budget-Limited Binned Ripple Adder

This block models, cycle for cycle, a ripple-carry adder that is clocked faster than its worst-case carry path. Every full-adder position has an integer propagation delay and every addition gets an integer time allowance. A carry appears at a position only when the whole ripple that feeds it fits inside that allowance; any carry whose chain runs out of time reads as 0. The result is a sum that is wrong only where long carry chains were cut short. The exact sum, the size of the error and a relative energy figure are reported beside it, so that the cost of a delay profile can be weighed against the accuracy it delivers.

The positions are grouped into a small number of equal, contiguous bins, and all positions in a bin share one delay value. Giving the high-order bins shorter delays (which stands for a higher supply) protects the significant bits. The energy figure is the sum over positions of the reciprocal square of each delay, in unsigned fixed point with 16 fraction bits.

Operands, the allowance and the bin delays are sampled on a clock edge where `inValid` is high, and all results appear together one cycle later and are held until the next accepted operation.

Top module: `binnedRippleAdder`

## Requirements
- R1: While `rstN` is low, `outValid`, `approxSum`, `exactSum`, `errMag` and `energyCost` are all 0.
- R2: `outValid` is high in the cycle after an edge where `inValid` was sampled high and low after an edge where it was low; after an edge with `inValid` low, all result outputs keep their previous values.
- R3: `exactSum` is the true 17-bit sum of the two operands sampled with the operation.
- R4: When the allowance is at least the sum of all position delays, `approxSum` equals `exactSum` and `errMag` is 0.
- R5: The carry into position k+1 equals the exact majority carry computed over positions L..k with a zero carry into L, where L is the lowest position for which the delays of positions L through k add up to no more than the allowance; if the delay of position k alone exceeds the allowance, that carry is 0. Sum bit k is opA[k] XOR opB[k] XOR the carry into k (the carry into position 0 is 0), and bit 16 is the carry out of position 15.
- R6: Position i takes its delay from bin i/4; bin b is the 8-bit field `binDelay[8b+7:8b]`, so bin 0 (lowest bits) serves the least significant positions.
- R7: With an allowance of 0 and all bin delays nonzero, `approxSum` is opA XOR opB with bit 16 clear; with all delays 0, every carry survives even at an allowance of 0.
- R8: `errMag` is the absolute difference between `exactSum` and `approxSum`.
- R9: `energyCost` is the sum over all 16 positions of floor(65536 / d²), where d is the position's delay and a delay of 0 counts as 1.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Accept the operands, allowance and delays on this edge |
| opA | input | 16 | First operand |
| opB | input | 16 | Second operand |
| budget | input | 8 | Time allowance for the whole addition |
| binDelay | input | 32 | Four 8-bit per-bin delays, bin 0 in the low byte |
| outValid | output | 1 | Results of the operation accepted on the last edge |
| approxSum | output | 17 | Sum with out-of-time carries forced to 0 |
| exactSum | output | 17 | Correct sum |
| errMag | output | 18 | Absolute difference of the two sums |
| energyCost | output | 22 | Sum of reciprocal squared delays, 16 fraction bits |

## Verification
Loading a new operation and presenting the previous one fall in the same cycle whenever `inValid` stays high on consecutive edges, so the results of one operation must be replaced in full by the next with no mixing of fields. The bench provokes this with bursts of back-to-back operations whose operands, allowances and delay profiles all change from one edge to the next, interleaved with idle gaps that must leave the outputs frozen. A behavioural model in the bench, built on delay sums rather than a budget countdown, predicts every output for every clock and is compared at the falling edge of each cycle.

// File: rtl/binAddPkg.sv
package binAddPkg;

  // Strobes from the control unit to the datapath.
  typedef struct packed {
    logic capture;   // register a fresh set of results this edge
  } stepStrobe_t;

  // Carry of a full adder.
  function automatic logic majority3(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

  // Fixed-point reciprocal square, used only to fill constant tables.
  function automatic int unsigned recipSq(input int unsigned dly, input int unsigned frac);
    int unsigned dd;
    dd = (dly == 0) ? 1 : dly;
    return (32'd1 << frac) / (dd * dd);
  endfunction

endpackage

// File: rtl/carryReach.sv
// Carry out of position TOP under a time allowance: walks down from TOP,
// spending each position's delay, then ripples upward over the reachable part.
module carryReach #(
  parameter int DELAY_W = 8,
  parameter int TOP     = 0
) (
  input  logic [TOP:0]                 opA,
  input  logic [TOP:0]                 opB,
  input  logic [(TOP+1)*DELAY_W-1:0]   posDelay,
  input  logic [DELAY_W-1:0]           budget,
  output logic                         carryOut
);
  import binAddPkg::*;

  logic [TOP:0]         reach;
  logic [DELAY_W-1:0]   remain;
  logic [DELAY_W-1:0]   stepDly;
  logic                 stillOk;
  logic                 ripple;

  always_comb begin
    remain  = budget;
    stillOk = 1'b1;
    reach   = '0;
    stepDly = '0;
    for (int j = TOP; j >= 0; j--) begin
      stepDly  = posDelay[j*DELAY_W +: DELAY_W];
      stillOk  = stillOk && (remain >= stepDly);
      reach[j] = stillOk;
      remain   = stillOk ? (remain - stepDly) : '0;
    end
  end

  always_comb begin
    ripple = 1'b0;
    for (int j = 0; j <= TOP; j++) begin
      ripple = reach[j] & majority3(opA[j], opB[j], ripple);
    end
    carryOut = ripple;
  end

endmodule

// File: rtl/binEnergy.sv
// Energy share of one bin: table lookup of the reciprocal square, times the
// number of positions in the bin.
module binEnergy #(
  parameter int DELAY_W  = 8,
  parameter int FRAC     = 16,
  parameter int ENERGY_W = 22,
  parameter int PER_BIN  = 4
) (
  input  logic [DELAY_W-1:0]  dly,
  output logic [ENERGY_W-1:0] cost
);
  import binAddPkg::*;

  localparam int RECIP_W = FRAC + 1;
  localparam int DEPTH   = 1 << DELAY_W;

  logic [RECIP_W-1:0] romTbl [DEPTH];

  for (genvar v = 0; v < DEPTH; v++) begin : g_rom
    assign romTbl[v] = RECIP_W'(recipSq(v, FRAC));
  end

  assign cost = ENERGY_W'(romTbl[dly]) * ENERGY_W'(PER_BIN);

endmodule

// File: rtl/binAddDatapath.sv
module binAddDatapath #(
  parameter int WIDTH   = 16,
  parameter int BINS    = 4,
  parameter int DELAY_W = 8,
  parameter int FRAC    = 16
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  binAddPkg::stepStrobe_t              strobe,
  input  logic [WIDTH-1:0]                    opA,
  input  logic [WIDTH-1:0]                    opB,
  input  logic [DELAY_W-1:0]                  budget,
  input  logic [BINS*DELAY_W-1:0]             binDelay,
  output logic [WIDTH:0]                      approxSum,
  output logic [WIDTH:0]                      exactSum,
  output logic [WIDTH+1:0]                    errMag,
  output logic [FRAC+$clog2(WIDTH+1):0]       energyCost
);
  localparam int PER_BIN  = WIDTH / BINS;
  localparam int SUM_W    = WIDTH + 1;
  localparam int ERR_W    = WIDTH + 2;
  localparam int ENERGY_W = FRAC + 1 + $clog2(WIDTH + 1);

  logic [WIDTH*DELAY_W-1:0] posDelay;
  logic [WIDTH:0]           carryIn;
  logic [SUM_W-1:0]         approxNext;
  logic [SUM_W-1:0]         exactNext;
  logic [ERR_W-1:0]         errNext;
  logic [ENERGY_W-1:0]      binCost [BINS];
  logic [ENERGY_W-1:0]      energyNext;

  // Spread each bin's delay over its positions.
  for (genvar i = 0; i < WIDTH; i++) begin : g_spread
    assign posDelay[i*DELAY_W +: DELAY_W] = binDelay[(i / PER_BIN)*DELAY_W +: DELAY_W];
  end

  // One independent budget walk per carry.
  assign carryIn[0] = 1'b0;
  for (genvar k = 0; k < WIDTH; k++) begin : g_carry
    carryReach #(.DELAY_W(DELAY_W), .TOP(k)) u_reach (
      .opA      (opA[k:0]),
      .opB      (opB[k:0]),
      .posDelay (posDelay[(k+1)*DELAY_W-1:0]),
      .budget   (budget),
      .carryOut (carryIn[k+1])
    );
  end

  assign approxNext = {carryIn[WIDTH], opA ^ opB ^ carryIn[WIDTH-1:0]};
  assign exactNext  = {1'b0, opA} + {1'b0, opB};
  assign errNext    = (exactNext >= approxNext) ? ERR_W'(exactNext - approxNext)
                                                : ERR_W'(approxNext - exactNext);

  for (genvar b = 0; b < BINS; b++) begin : g_energy
    binEnergy #(
      .DELAY_W (DELAY_W),
      .FRAC    (FRAC),
      .ENERGY_W(ENERGY_W),
      .PER_BIN (PER_BIN)
    ) u_bin (
      .dly  (binDelay[b*DELAY_W +: DELAY_W]),
      .cost (binCost[b])
    );
  end

  always_comb begin
    energyNext = '0;
    for (int b = 0; b < BINS; b++) begin
      energyNext = energyNext + binCost[b];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      approxSum  <= '0;
      exactSum   <= '0;
      errMag     <= '0;
      energyCost <= '0;
    end else if (strobe.capture) begin
      approxSum  <= approxNext;
      exactSum   <= exactNext;
      errMag     <= errNext;
      energyCost <= energyNext;
    end
  end

endmodule

// File: rtl/binAddCtrl.sv
module binAddCtrl (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inValid,
  output binAddPkg::stepStrobe_t strobe,
  output logic                   outValid
);

  assign strobe.capture = inValid;

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

endmodule

// File: rtl/binnedRippleAdder.sv
module binnedRippleAdder #(
  parameter int WIDTH   = 16,
  parameter int BINS    = 4,
  parameter int DELAY_W = 8,
  parameter int FRAC    = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          inValid,
  input  logic [WIDTH-1:0]              opA,
  input  logic [WIDTH-1:0]              opB,
  input  logic [DELAY_W-1:0]            budget,
  input  logic [BINS*DELAY_W-1:0]       binDelay,
  output logic                          outValid,
  output logic [WIDTH:0]                approxSum,
  output logic [WIDTH:0]                exactSum,
  output logic [WIDTH+1:0]              errMag,
  output logic [FRAC+$clog2(WIDTH+1):0] energyCost
);
  import binAddPkg::*;

  stepStrobe_t strobe;

  binAddCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  binAddDatapath #(
    .WIDTH   (WIDTH),
    .BINS    (BINS),
    .DELAY_W (DELAY_W),
    .FRAC    (FRAC)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .opA        (opA),
    .opB        (opB),
    .budget     (budget),
    .binDelay   (binDelay),
    .approxSum  (approxSum),
    .exactSum   (exactSum),
    .errMag     (errMag),
    .energyCost (energyCost)
  );

endmodule

// File: rtl/binnedRippleAdderChk.sv
module binnedRippleAdderChk #(
  parameter int WIDTH   = 16,
  parameter int BINS    = 4,
  parameter int DELAY_W = 8,
  parameter int FRAC    = 16
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          inValid,
  input logic [WIDTH-1:0]              opA,
  input logic [WIDTH-1:0]              opB,
  input logic [DELAY_W-1:0]            budget,
  input logic [BINS*DELAY_W-1:0]       binDelay,
  input logic                          outValid,
  input logic [WIDTH:0]                approxSum,
  input logic [WIDTH:0]                exactSum,
  input logic [WIDTH+1:0]              errMag,
  input logic [FRAC+$clog2(WIDTH+1):0] energyCost
);
  localparam int PER_BIN = WIDTH / BINS;

  logic [31:0] totalDelay;
  logic        allNonzero;

  always_comb begin
    totalDelay = '0;
    allNonzero = 1'b1;
    for (int b = 0; b < BINS; b++) begin
      totalDelay = totalDelay + 32'(PER_BIN) * 32'(binDelay[b*DELAY_W +: DELAY_W]);
      if (binDelay[b*DELAY_W +: DELAY_W] == '0) allNonzero = 1'b0;
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R2
  idle_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  // R2
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(approxSum) && $stable(exactSum) &&
                  $stable(errMag) && $stable(energyCost)));

  // R3
  exact_sum_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> exactSum == ((WIDTH+1)'($past(opA)) + (WIDTH+1)'($past(opB))));

  // R4
  full_budget_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (32'(budget) >= totalDelay)) |=> approxSum == exactSum);

  // R7
  zero_budget_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && budget == '0 && allNonzero) |=> approxSum == {1'b0, $past(opA ^ opB)});

  // R8
  no_error_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && approxSum == exactSum) |-> errMag == '0);

endmodule

bind binnedRippleAdder binnedRippleAdderChk #(
  .WIDTH   (WIDTH),
  .BINS    (BINS),
  .DELAY_W (DELAY_W),
  .FRAC    (FRAC)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .opA        (opA),
  .opB        (opB),
  .budget     (budget),
  .binDelay   (binDelay),
  .outValid   (outValid),
  .approxSum  (approxSum),
  .exactSum   (exactSum),
  .errMag     (errMag),
  .energyCost (energyCost)
);

// File: tb/tb_binnedRippleAdder.sv
`timescale 1ns/1ps
module tb_binnedRippleAdder;
  localparam int WIDTH = 16;
  localparam int BINS  = 4;
  localparam int PER   = WIDTH / BINS;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [15:0] opA = '0;
  logic [15:0] opB = '0;
  logic [7:0]  budget = '0;
  logic [31:0] binDelay = '0;
  logic        outValid;
  logic [16:0] approxSum;
  logic [16:0] exactSum;
  logic [17:0] errMag;
  logic [21:0] energyCost;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // expected outputs, advanced by the model on every rising edge
  logic        expValid = 1'b0;
  logic [16:0] expApprox = '0;
  logic [16:0] expExact = '0;
  logic [17:0] expErr = '0;
  logic [21:0] expEnergy = '0;

  always #5 clk = ~clk;

  binnedRippleAdder dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .budget(budget), .binDelay(binDelay), .outValid(outValid),
    .approxSum(approxSum), .exactSum(exactSum), .errMag(errMag),
    .energyCost(energyCost)
  );

  function automatic int posDly(input logic [31:0] bd, input int i);
    return int'(bd[(i / PER)*8 +: 8]);
  endfunction

  // Carry k+1 from the lowest start whose delay sum fits the allowance.
  function automatic logic [16:0] refApprox(input logic [15:0] a, input logic [15:0] b,
                                            input int bud, input logic [31:0] bd);
    logic [16:0] cr;
    logic [16:0] r;
    int low;
    int acc;
    logic c;
    cr = '0;
    for (int k = 0; k < WIDTH; k++) begin
      low = -1;
      acc = 0;
      for (int j = k; j >= 0; j--) begin
        if (acc + posDly(bd, j) > bud) break;
        acc = acc + posDly(bd, j);
        low = j;
      end
      c = 1'b0;
      if (low >= 0) begin
        for (int j = low; j <= k; j++) c = (a[j] & b[j]) | (a[j] & c) | (b[j] & c);
      end
      cr[k+1] = c;
    end
    r[15:0] = a ^ b ^ cr[15:0];
    r[16]   = cr[16];
    return r;
  endfunction

  function automatic int refEnergy(input logic [31:0] bd);
    int e;
    int dd;
    e = 0;
    for (int i = 0; i < WIDTH; i++) begin
      dd = (posDly(bd, i) == 0) ? 1 : posDly(bd, i);
      e = e + 65536 / (dd * dd);
    end
    return e;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      expValid <= 1'b0;
      expApprox <= '0; expExact <= '0; expErr <= '0; expEnergy <= '0;
    end else begin
      expValid <= inValid;
      if (inValid) begin
        logic [16:0] ap;
        logic [16:0] ex;
        ap = refApprox(opA, opB, int'(budget), binDelay);
        ex = 17'({1'b0, opA} + {1'b0, opB});
        expApprox <= ap;
        expExact  <= ex;
        expErr    <= (ex >= ap) ? 18'(ex - ap) : 18'(ap - ex);
        expEnergy <= 22'(refEnergy(binDelay));
      end
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R2 outValid",   64'(outValid),   64'(expValid));
      check("R3 exactSum",   64'(exactSum),   64'(expExact));
      check("R5 approxSum",  64'(approxSum),  64'(expApprox));
      check("R8 errMag",     64'(errMag),     64'(expErr));
      check("R9 energyCost", 64'(energyCost), 64'(expEnergy));
    end
  end

  task automatic drive(input logic [15:0] a, input logic [15:0] b,
                       input logic [7:0] bud, input logic [31:0] bd);
    @(negedge clk);
    inValid = 1'b1; opA = a; opB = b; budget = bud; binDelay = bd;
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0;
    opA = 16'hA5A5; opB = 16'h5A5A; budget = 8'd3; binDelay = 32'h0909_0909;
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    inValid = 1'b1; opA = 16'hFFFF; opB = 16'h0001; binDelay = 32'h0101_0101;
    @(negedge clk);
    check("R1 outValid",   64'(outValid),   64'd0);
    check("R1 approxSum",  64'(approxSum),  64'd0);
    check("R1 exactSum",   64'(exactSum),   64'd0);
    check("R1 errMag",     64'(errMag),     64'd0);
    check("R1 energyCost", 64'(energyCost), 64'd0);
    inValid = 1'b0;
    rstN = 1'b1;

    // R4: allowance exactly equals total delay (16*3)
    drive(16'hFFFF, 16'h0001, 8'd48, 32'h0303_0303);
    idle();
    check("R4 approx equals exact", 64'(approxSum), 64'h10000);
    check("R4 zero error",          64'(errMag),    64'd0);

    // R5: one unit short; only the top carry loses its generating position
    drive(16'hFFFF, 16'h0001, 8'd47, 32'h0303_0303);
    idle();
    check("R5 top carry cut", 64'(approxSum), 64'd0);
    check("R5 error size",    64'(errMag),    64'h10000);

    // R6: bin 0 fast, upper bins slow
    drive(16'h000F, 16'h0001, 8'd5, 32'h6464_6401);
    idle();
    check("R6 ripple inside bin 0", 64'(approxSum), 64'h10);
    drive(16'h001F, 16'h0001, 8'd5, 32'h6464_6401);
    idle();
    check("R6 cut at bin 1", 64'(approxSum), 64'd0);
    check("R6 error",        64'(errMag),    64'h20);

    // R7: zero allowance
    drive(16'h1234, 16'h0FF0, 8'd0, 32'h0202_0202);
    idle();
    check("R7 xor only", 64'(approxSum), 64'h1DC4);
    check("R7 exact",    64'(exactSum),  64'h2224);
    drive(16'hFFFF, 16'h0001, 8'd0, 32'h0000_0000);
    idle();
    check("R7 zero delays keep carries", 64'(approxSum), 64'h10000);

    // R9: energy of distinct bins and of all-zero delays
    drive(16'h0000, 16'h0000, 8'd0, 32'h0403_0201);
    idle();
    check("R9 mixed bins", 64'(energyCost), 64'd373188);
    drive(16'h0000, 16'h0000, 8'd0, 32'h0000_0000);
    idle();
    check("R9 zero counts as one", 64'(energyCost), 64'd1048576);

    // R2: back-to-back loads with changing profiles, then idle gaps
    drive(16'h7FFF, 16'h0001, 8'd20, 32'h0102_0304);
    drive(16'h8000, 16'h8000, 8'd1,  32'h0101_0101);
    drive(16'h0F0F, 16'hF0F1, 8'd9,  32'h0001_0203);
    idle();
    idle();
    idle();

    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 3) == 0) idle();
      else drive(16'($urandom()), 16'($urandom()), 8'($urandom_range(0, 80)),
                 {8'($urandom_range(0, 12)), 8'($urandom_range(0, 12)),
                  8'($urandom_range(0, 12)),
                  ($urandom_range(0, 7) == 0) ? 8'd255 : 8'($urandom_range(0, 12))});
    end
    idle();
    idle();
    finishRun();
  end

endmodule